// File: doc/BRIEF.md
# Multiplier-Chain MSK Modulator

This block turns a serial bit stream into a single stream of signed baseband samples that carry minimum shift keying. Incoming bits are dealt out in turn to an in-phase and a quadrature channel. In each channel the held bit becomes a fixed-point +1 or −1. That value scales a half-sine weighting sample in a first multiplier. The result then scales a carrier sample in a second multiplier that follows the first. The quadrature bit passes through a half-period shift register before it enters its channel. The two channel products are added into a 9-bit output sample.

The timing reference is a sample clock enable. Every enabled clock moves a 200-step sample counter forward. When the counter wraps, the two bits gathered during the period just ended take effect. The bit separator is a two-state machine. SEP_I waits for the in-phase bit and SEP_Q waits for the quadrature bit. Transition I_TAKEN (SEP_I→SEP_Q) fires on a valid bit in SEP_I. Transition Q_TAKEN (SEP_Q→SEP_I) fires on a valid bit in SEP_Q. Transition PERIOD_RESTART (either state→SEP_I) fires on a counter wrap and takes priority over the other two.

Top module: `msk_mult_mod`

## Requirements
- R1: While rst_n is low, sample_out is 0, the counter is at 0, the separator is in SEP_I, and every pending and held bit is 0.
- R2: The sample counter steps from 0 to 199 and back to 0, and it moves only on clocks where samp_en is 1. On a clock with samp_en 0, sample_out and the whole sample pipeline keep their values.
- R3: Within a counter period, the first valid bit goes to the pending I bit and the second goes to the pending Q bit. A third valid bit replaces the pending I bit. A pending bit that receives no new bit in a period keeps its old value. The pairing starts again at SEP_I after every wrap.
- R4: When bit_valid is 0, bit_in has no effect.
- R5: The pending bits of period p become active at the wrap that ends period p. The I bit drives counter indices 0 to 199 of period p+1. The Q bit drives from index 100 of period p+1 through index 99 of period p+2.
- R6: A held bit of 1 maps to +64 and a held bit of 0 maps to −64. These are ±1.0 with 6 fraction bits. The held bits after reset count as 0.
- R7: The weight table is W(x) = floor(127·16·x·(200−x) / (5·200² − 4·x·(200−x))) for x from 0 to 199. At counter index n the I weight is W(n) and the Q weight is W((n+100) mod 200).
- R8: With a = (10·n) mod 400, which gives 5 carrier cycles per period, S(a) = W(a) for a < 200 and −W(a−200) otherwise. The I carrier is S((a+100) mod 400) and the Q carrier is S(a).
- R9: The first multiplier gives (±64·weight) >>> 6 and the second gives (first·carrier) >>> 7. Both are arithmetic shifts (floor), and both results are kept to 8 bits. sample_out is the 9-bit signed sum of the I and Q results.
- R10: The sample for the tick at counter index n is on sample_out after the fourth enabled edge, counting that tick's own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Sample clock enable: one tick per output sample |
| bit_valid | input | 1 | bit_in carries a message bit on this clock |
| bit_in | input | 1 | Serial message bit |
| sample_out | output | 9 | Signed MSK sample, I plus Q |

## Verification
The assertions assume that bit_valid is never high on the same clock as a counter wrap. They also assume the source supplies its bits for a period between wraps. The stimulus places every valid bit at chosen counter indices that lie away from index 199. Bits are injected only on enabled clocks, so each injection position is used exactly once even while samp_en is gapped. bit_in is toggled freely whenever bit_valid is low.

// File: rtl/msk_pkg.sv
package msk_pkg;

    typedef enum logic {
        SEP_I = 1'b0,
        SEP_Q = 1'b1
    } sep_state_t;

    // Rational half-sine over x in [0, len], peak amp at len/2.
    function automatic int half_sine(input int x, input int len, input int amp);
        int prod;
        prod = x * (len - x);
        return (amp * 16 * prod) / (5 * len * len - 4 * prod);
    endfunction

    // Full-turn sine, angle a in [0, 2*len).
    function automatic int full_sine(input int a, input int len, input int amp);
        if (a < len) return half_sine(a, len, amp);
        return -half_sine(a - len, len, amp);
    endfunction

endpackage

// File: rtl/msk_bit_split.sv
module msk_bit_split
    import msk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic wrap,
    output logic act_i,
    output logic q_hold
);

    sep_state_t st, st_nxt;
    logic pend_i, pend_q;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SEP_I: if (bit_valid) st_nxt = SEP_Q;
            SEP_Q: if (bit_valid) st_nxt = SEP_I;
        endcase
        if (wrap) st_nxt = SEP_I;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEP_I;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_i <= 1'b0;
            pend_q <= 1'b0;
            act_i  <= 1'b0;
            q_hold <= 1'b0;
        end else begin
            if (bit_valid) begin
                unique case (st)
                    SEP_I: pend_i <= bit_in;
                    SEP_Q: pend_q <= bit_in;
                endcase
            end
            if (wrap) begin
                act_i  <= pend_i;
                q_hold <= pend_q;
            end
        end
    end

    assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> ($stable(pend_i) && $stable(pend_q)));

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st == SEP_I));

    assert_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_i) && $stable(q_hold)));

endmodule

// File: rtl/msk_qdelay.sv
module msk_qdelay #(
    parameter int DEPTH = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);

    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n)  sr <= '0;
        else if (en) sr <= {sr[DEPTH-2:0], d};
    end

    assign q = sr[DEPTH-1];

endmodule

// File: rtl/msk_rom.sv
module msk_rom
    import msk_pkg::*;
#(
    parameter int PER  = 200,
    parameter int KCYC = 5,
    parameter int SW   = 8,
    parameter bit IS_Q = 1'b0,
    localparam int CW  = $clog2(PER)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [CW-1:0]        idx,
    output logic signed [SW-1:0] w_o,
    output logic signed [SW-1:0] c_o
);

    localparam int AMP = 2 ** (SW - 1) - 1;

    logic signed [SW-1:0] w_tbl [PER];
    logic signed [SW-1:0] c_tbl [PER];

    for (genvar g = 0; g < PER; g++) begin : g_tab
        localparam int WX = IS_Q ? (g + PER / 2) % PER : g;
        localparam int AN = (2 * KCYC * g) % (2 * PER);
        localparam int CA = IS_Q ? AN : (AN + PER / 2) % (2 * PER);
        assign w_tbl[g] = SW'(half_sine(WX, PER, AMP));
        assign c_tbl[g] = SW'(full_sine(CA, PER, AMP));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_o <= '0;
            c_o <= '0;
        end else if (en) begin
            w_o <= w_tbl[idx];
            c_o <= c_tbl[idx];
        end
    end

endmodule

// File: rtl/msk_chan.sv
module msk_chan #(
    parameter int SW   = 8,
    parameter int FRAC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 bit_i,
    input  logic signed [SW-1:0] w_i,
    input  logic signed [SW-1:0] c_i,
    output logic signed [SW-1:0] prod_o
);

    localparam int PW = 2 * SW;
    localparam logic signed [SW-1:0] P_ONE = SW'(2 ** FRAC);
    localparam logic signed [SW-1:0] N_ONE = SW'(-(2 ** FRAC));

    logic signed [SW-1:0] nrz_r, m1, c_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrz_r  <= '0;
            m1     <= '0;
            c_d    <= '0;
            prod_o <= '0;
        end else if (en) begin
            nrz_r  <= bit_i ? P_ONE : N_ONE;
            m1     <= SW'((PW'(nrz_r) * PW'(w_i)) >>> FRAC);
            c_d    <= c_i;
            prod_o <= SW'((PW'(m1) * PW'(c_d)) >>> (SW - 1));
        end
    end

    assert_stage1_mag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((m1 == $past(w_i)) || (m1 == -$past(w_i))));

endmodule

// File: rtl/msk_mult_mod.sv
module msk_mult_mod #(
    parameter int PER  = 200,
    parameter int KCYC = 5,
    parameter int SW   = 8,
    parameter int FRAC = 6,
    localparam int OW  = SW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_en,
    input  logic                 bit_valid,
    input  logic                 bit_in,
    output logic signed [OW-1:0] sample_out
);

    localparam int CW   = $clog2(PER);
    localparam int HALF = PER / 2;

    logic [CW-1:0] cnt;
    logic wrap, act_i, q_hold, q_dly;
    logic signed [SW-1:0] w_i, c_i, w_q, c_q, prod_i, prod_q;

    assign wrap = samp_en && (cnt == CW'(PER - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (wrap)    cnt <= '0;
        else if (samp_en) cnt <= cnt + 1'b1;
    end

    msk_bit_split u_split (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .wrap(wrap), .act_i(act_i), .q_hold(q_hold)
    );

    msk_qdelay #(.DEPTH(HALF)) u_qdly (
        .clk(clk), .rst_n(rst_n), .en(samp_en), .d(q_hold), .q(q_dly)
    );

    msk_rom #(.PER(PER), .KCYC(KCYC), .SW(SW), .IS_Q(1'b0)) u_rom_i (
        .clk(clk), .rst_n(rst_n), .en(samp_en), .idx(cnt), .w_o(w_i), .c_o(c_i)
    );

    msk_rom #(.PER(PER), .KCYC(KCYC), .SW(SW), .IS_Q(1'b1)) u_rom_q (
        .clk(clk), .rst_n(rst_n), .en(samp_en), .idx(cnt), .w_o(w_q), .c_o(c_q)
    );

    msk_chan #(.SW(SW), .FRAC(FRAC)) u_chan_i (
        .clk(clk), .rst_n(rst_n), .en(samp_en), .bit_i(act_i),
        .w_i(w_i), .c_i(c_i), .prod_o(prod_i)
    );

    msk_chan #(.SW(SW), .FRAC(FRAC)) u_chan_q (
        .clk(clk), .rst_n(rst_n), .en(samp_en), .bit_i(q_dly),
        .w_i(w_q), .c_i(c_q), .prod_o(prod_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       sample_out <= '0;
        else if (samp_en) sample_out <= OW'(prod_i) + OW'(prod_q);
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(sample_out));

    assert_qdelay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_dly) |-> (cnt == CW'(HALF)));

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(cnt));

endmodule

// File: tb/msk_mult_mod_bench.sv
`timescale 1ns/1ps
module msk_mult_mod_bench;

    localparam int PER = 200;
    localparam int NPER = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_en = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic signed [8:0] sample_out;

    always #4 clk = ~clk;

    msk_mult_mod u_msk_mult_mod (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
        .bit_valid(bit_valid), .bit_in(bit_in), .sample_out(sample_out)
    );

    int checks = 0;
    int fails = 0;
    bit iper [32];
    bit qper [32];

    // R7 weight
    function automatic int hs(input int x);
        int p = x * (PER - x);
        return (127 * 16 * p) / (5 * PER * PER - 4 * p);
    endfunction

    // R8 carrier
    function automatic int fs(input int a);
        if (a < PER) return hs(a);
        return -hs(a - PER);
    endfunction

    // R5 R6 R9 expected sample of tick t
    function automatic int expf(input int t);
        int n = t % PER;
        int p = t / PER;
        int tq = t - PER / 2;
        bit bi = (p >= 1) ? iper[p-1] : 1'b0;
        bit bq = (tq >= PER) ? qper[tq / PER - 1] : 1'b0;
        int wi = hs(n);
        int wq = hs((n + PER / 2) % PER);
        int a = (10 * n) % (2 * PER);
        int mi = bi ? wi : -wi;
        int mq = bq ? wq : -wq;
        return ((mi * fs((a + PER / 2) % (2 * PER))) >>> 7) + ((mq * fs(a)) >>> 7);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int T = 0;
        bit m_pi = 1'b0, m_pq = 1'b0, m_st = 1'b0;
        repeat (3) @(negedge clk);
        chk(sample_out == 0, "R1 reset output", sample_out, 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 100000; cyc++) begin
            int p = T / PER;
            int n = T % PER;
            bit en, v, b, bI, bQ;
            int te;
            string tag;
            if (p >= NPER) break;
            // R2: gapped enable in the second half
            en = (p < 10) ? 1'b1 : (cyc % 3 != 2);
            bI = p[1] ^ p[3];
            bQ = p[0] ^ p[2];
            v = 1'b0;
            b = 1'b0;
            if (en) begin
                if (p % 7 == 5) begin
                    // R3: third bit overwrites pending I
                    if (n == 30)  begin v = 1'b1; b = bI;  end
                    if (n == 80)  begin v = 1'b1; b = bQ;  end
                    if (n == 150) begin v = 1'b1; b = ~bI; end
                end else if (p % 7 == 6) begin
                    // R3: only an I bit, pending Q keeps its value
                    if (n == 60) begin v = 1'b1; b = bI; end
                end else begin
                    if (n == 30)  begin v = 1'b1; b = bI; end
                    if (n == 120) begin v = 1'b1; b = bQ; end
                end
            end
            if (v) begin
                if (!m_st) m_pi = b;
                else       m_pq = b;
                m_st = ~m_st;
            end
            if (en && n == PER - 1) begin
                iper[p] = m_pi;
                qper[p] = m_pq;
                m_st = 1'b0;
            end
            samp_en = en;
            bit_valid = v;
            // R4: bit_in wanders while bit_valid is low
            bit_in = v ? b : (cyc[0] ^ cyc[2]);
            @(posedge clk);
            if (en) T++;
            @(negedge clk);
            if (T < 4) begin
                chk(sample_out == 0, "R1 R10 pipeline empty", sample_out, 0);
            end else begin
                te = T - 4;
                tag = "R4 R5 R6 R7 R8 R9 R10";
                if (te >= 10 * PER) tag = {tag, " R2"};
                if (te / PER >= 1 && ((te / PER - 1) % 7) >= 5) tag = {tag, " R3"};
                chk(sample_out == expf(te), tag, sample_out, expf(te));
            end
        end
        samp_en = 1'b0;
        bit_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule